// File: doc/BRIEF.md
# Backplane Control Register with Timed Reset Pulse

This block is one 16-bit control register inside a bus-bridge module. Software writes it to steer an external trigger between the backplane and a pair of front connectors, to pull the backplane's system-fail line, to enable interlocked arbitration, and to fire a system-reset pulse. The trigger path is steered by two fields that work together. One field enables routing. The other picks the direction, and it only matters while routing is enabled.

The reset-pulse field is write-one-to-start. Once started, the block holds its reset-line pull output for a fixed number of clock cycles, at least 200 ms, and then clears the field by itself. The fields do not all respond to the two resets in the same way. A hard reset (asynchronous, active low) clears every field and aborts any pulse. A soft reset (synchronous) clears only the fail field and the pulse field, and it leaves routing and interlock untouched.

The outputs for the fail and reset lines are open-drain-style: a 1 means "pull the line to its asserted level". Bus drivers and the arbiter sit outside this block.

Top module: `bpctl_reg`

## Requirements
- R1: While and after hard reset, every field reads 0, `rdata` is 0x0000, and all outputs are 0.
- R2: Bit 11 enables trigger routing and bit 10 selects its direction. When bit 11 is 0, both `trig_out_en` and `trig_in_en` are 0. When bit 11 is 1, bit 10 = 0 raises only `trig_out_en` (backplane to output connector), and bit 10 = 1 raises only `trig_in_en` (input connector to backplane).
- R3: Bit 9 takes the written value on every write, and `fail_pull` equals bit 9.
- R4: Writing 1 to bit 8 while no pulse runs raises `rst_pull` for exactly CLK_HZ/1000*PULSE_MS cycles, starting the cycle after the write. Bit 8 then clears by itself.
- R5: Bit 8 reads 1 for every cycle in which `rst_pull` is 1, and reads 0 otherwise.
- R6: While a pulse runs, a write of 1 to bit 8 neither restarts it nor shortens it. A write of 0 to bit 8 never stops a pulse.
- R7: Bits 15:12 and 7:1 always read 0, and writes to them have no effect on any output.
- R8: Bit 0 takes the written value, and `interlock_en` equals bit 0.
- R9: A soft reset clears bits 9 and 8 (aborting any pulse) and keeps bits 11, 10 and 0. When a soft reset and a write fall in the same cycle, the soft reset wins for bits 9 and 8.
- R10: A hard reset during a pulse drops `rst_pull` at once, and no pulse resumes after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| wr_en | input | 1 | Write strobe for the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Current register contents |
| trig_out_en | output | 1 | Route the backplane trigger to the output connector |
| trig_in_en | output | 1 | Route the input connector trigger to the backplane |
| fail_pull | output | 1 | Pull the system-fail line |
| rst_pull | output | 1 | Pull the system-reset line |
| interlock_en | output | 1 | Enable interlocked arbitration |

## Verification
The hardest cases to reach are those where something else happens while a reset pulse is already running. Examples are a second start write, a write of 0 to the pulse field, or a soft reset or hard reset part way through the pulse. The bench sets the clock parameter low so that a pulse lasts 200 cycles. It then starts a pulse and injects each of these events at a chosen cycle inside it. A free-running counter tallies the cycles in which `rst_pull` is high, and the bench compares that tally with the exact expected width.

// File: rtl/bpctl_reg.sv
module bpctl_reg #(
  parameter int CLK_HZ   = 125_000_000,
  parameter int PULSE_MS = 200
) (
  input  logic        clk,
  input  logic        hard_rst_n,
  input  logic        soft_rst,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        trig_out_en,
  output logic        trig_in_en,
  output logic        fail_pull,
  output logic        rst_pull,
  output logic        interlock_en
);
  localparam int PULSE_CYC = CLK_HZ / 1000 * PULSE_MS;
  localparam int CW        = (PULSE_CYC > 2) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYC - 1);

  logic          route_en, route_dir, fail_q, pulse_q, ilk_q;
  logic [CW-1:0] cnt;

  wire start = wr_en && wdata[8] && !pulse_q;

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      route_en  <= 1'b0;
      route_dir <= 1'b0;
      ilk_q     <= 1'b0;
    end else if (wr_en) begin
      route_en  <= wdata[11];
      route_dir <= wdata[10];
      ilk_q     <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n)   fail_q <= 1'b0;
    else if (soft_rst) fail_q <= 1'b0;
    else if (wr_en)    fail_q <= wdata[9];
  end

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      pulse_q <= 1'b0;
      cnt     <= '0;
    end else if (soft_rst) begin
      pulse_q <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      pulse_q <= 1'b1;
      cnt     <= CNT_LOAD;
    end else if (pulse_q) begin
      if (cnt == '0) pulse_q <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign rdata        = {4'b0, route_en, route_dir, fail_q, pulse_q, 7'b0, ilk_q};
  assign trig_out_en  = route_en && !route_dir;
  assign trig_in_en   = route_en && route_dir;
  assign fail_pull    = fail_q;
  assign rst_pull     = pulse_q;
  assign interlock_en = ilk_q;

  a_r4_pulse_load: assert property (@(posedge clk) disable iff (!hard_rst_n)
    $rose(rst_pull) |-> cnt == CNT_LOAD);

  a_r4_pulse_full: assert property (@(posedge clk) disable iff (!hard_rst_n)
    ($fell(rst_pull) && !$past(soft_rst)) |-> $past(cnt) == '0);

  a_r6_no_restart: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (rst_pull && cnt != '0 && !soft_rst) |=> (rst_pull && cnt == $past(cnt) - 1'b1));

  a_r3_fail_follows: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (wr_en && !soft_rst) |=> fail_pull == $past(wdata[9]));

  a_r9_soft_keeps: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (soft_rst && !wr_en) |=> (!fail_pull && !rst_pull &&
      interlock_en == $past(interlock_en) && trig_in_en == $past(trig_in_en) &&
      trig_out_en == $past(trig_out_en)));

  a_r2_one_path: assert property (@(posedge clk) disable iff (!hard_rst_n)
    !(trig_out_en && trig_in_en));
endmodule

// File: tb/bpctl_reg_test.sv
module bpctl_reg_test;
  localparam int NCYC = 200;

  logic clk = 1'b0, hard_rst_n = 1'b0, soft_rst = 1'b0, wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic trig_out_en, trig_in_en, fail_pull, rst_pull, interlock_en;

  int checks = 0, fails = 0, hi_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bpctl_reg #(.CLK_HZ(1000), .PULSE_MS(200)) uut (
    .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .trig_out_en(trig_out_en), .trig_in_en(trig_in_en),
    .fail_pull(fail_pull), .rst_pull(rst_pull), .interlock_en(interlock_en));

  always @(negedge clk) if (rst_pull) hi_cnt++;

  // {wdata, expected rdata, expected {out_en, in_en, fail, ilk}}
  localparam logic [35:0] VEC [11] = '{
    {16'h0000, 16'h0000, 4'b0000},
    {16'h0800, 16'h0800, 4'b1000},
    {16'h0C00, 16'h0C00, 4'b0100},
    {16'h0400, 16'h0400, 4'b0000},
    {16'h0200, 16'h0200, 4'b0010},
    {16'h0001, 16'h0001, 4'b0001},
    {16'h00FE, 16'h0000, 4'b0000},
    {16'hF000, 16'h0000, 4'b0000},
    {16'hFEFF, 16'h0E01, 4'b0111},
    {16'h0A01, 16'h0A01, 4'b1011},
    {16'h0000, 16'h0000, 4'b0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [3:0] outs();
    return {trig_out_en, trig_in_en, fail_pull, interlock_en};
  endfunction

  initial begin
    #1;
    chk("R1 rdata in reset", rdata, 16'h0);
    chk("R1 outputs in reset", {outs(), rst_pull}, 5'b0);
    repeat (2) @(negedge clk);
    hard_rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after reset", rdata, 16'h0);

    for (int i = 0; i < 11; i++) begin
      wr(VEC[i][35:20]);
      chk("R2/R3/R7/R8 vector rdata", rdata, VEC[i][19:4]);
      chk("R2/R3/R7/R8 vector outputs", outs(), VEC[i][3:0]);
    end

    // R4/R5: plain pulse
    hi_cnt = 0;
    wr(16'h0100);
    chk("R5 bit8 reads 1", rdata[8], 1'b1);
    repeat (100) @(negedge clk);
    chk("R5 bit8 mid pulse", rdata[8], 1'b1);
    while (rst_pull) @(negedge clk);
    chk("R4 pulse width", hi_cnt, NCYC);
    chk("R4 self clear", rdata, 16'h0);

    // R6: rewrites during pulse
    hi_cnt = 0;
    wr(16'h0100);
    repeat (60) @(negedge clk);
    wr(16'h0100);
    repeat (30) @(negedge clk);
    wr(16'h0000);
    chk("R6 write 0 keeps pulse", rst_pull, 1'b1);
    while (rst_pull) @(negedge clk);
    chk("R6 width unchanged", hi_cnt, NCYC);

    // R9: soft reset mid pulse
    wr(16'h0F01);
    chk("R9 setup", rdata, 16'h0F01);
    repeat (20) @(negedge clk);
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    chk("R9 soft reset rdata", rdata, 16'h0C01);
    chk("R9 soft reset outputs", {outs(), rst_pull}, 5'b01010);
    repeat (5) @(negedge clk);
    chk("R9 pulse stays off", rst_pull, 1'b0);

    // R9: soft reset with same-cycle write
    @(negedge clk); wr_en = 1'b1; wdata = 16'h0B00; soft_rst = 1'b1;
    @(negedge clk); wr_en = 1'b0; soft_rst = 1'b0;
    chk("R9 soft beats write", rdata, 16'h0800);
    chk("R9 soft beats write pins", {fail_pull, rst_pull}, 2'b00);

    // R10: hard reset mid pulse
    wr(16'h0D01);
    repeat (10) @(negedge clk);
    hard_rst_n = 1'b0; #1;
    chk("R10 immediate abort", {rdata, rst_pull}, 17'h0);
    @(negedge clk); hard_rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 no resume", {rdata, outs(), rst_pull}, 21'h0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule